// File: doc/BRIEF.md
# Programmable duty-cycle frequency doubler

This block turns a slow reference clock into a clock-like signal at twice its rate. The whole block runs from a fast sampling clock at 32 times the reference rate. The reference passes through a synchroniser. On each rising edge of the reference, a phase counter restarts. It counts the 32 sampling ticks of one reference period. The first 16 ticks form the first doubled cycle, which lies in the high phase of the reference. The last 16 ticks form the second doubled cycle, which lies in the low phase.

An 8-bit duty register holds a separate 4-bit high-time code for each doubled cycle, so the two pulses in one period can differ. The block copies the duty register into an active copy only at a reference rising edge. A running period therefore never changes shape. A mode register turns the doubler on. A select register routes the doubled signal to either or both of two outputs, a fast-clock output and a system-clock output. Every output that is not selected stays low.

Top module: `duty_doubler`

## Requirements
- R1: While reset is high and on the first sample after it, both outputs are low.
- R2: The reference passes through two synchronising flops. If the first sampling edge that sees the reference high is edge 1, the output bit for phase 0 appears after edge 4, and the output bit for phase k appears k edges later. Phase 0 and phase 16 are always high in an active period.
- R3: The first doubled cycle (phases 0 to 15) uses the code A = {duty[7], duty[5:3]}. The output is high for phases 0 through A, which is A+1 ticks out of 16.
- R4: The second doubled cycle (phases 16 to 31) uses the code B = {duty[6], duty[2:0]}. The output is high for phases 16 through 16+B.
- R5: A write to the duty register changes the output only from the next reference rising edge. A write accepted by the edge before the reload edge takes part in that reload. A write accepted on the same edge as the reload waits for the following period.
- R6: When bit 4 of the mode register (address 0) is 0, both outputs are low.
- R7: The select register is at address 1. The fast-clock output follows the doubler only when bits [5:4] are 01. The system-clock output follows it only when bits [7:6] are 01. Any other value of a field holds that output low.
- R8: With no new reference rising edge, the phase counter holds at 31. Both outputs stay low after the tick for phase 31.
- R9: The duty register is at address 2. A write to address 3 has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, 32 times the reference rate |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | Reference clock, asynchronous to clk |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address: 0 mode, 1 select, 2 duty |
| cfg_wdata_i | input | 8 | Register write data |
| fast_clk_o | output | 1 | Doubled output routed by select bits [5:4] |
| sys_clk_o | output | 1 | Doubled output routed by select bits [7:6] |

## Verification
A duty register write can land on the same sampling edge that reloads the active duty copy at a reference rising edge. The bench provokes this on purpose with directed writes one tick before that edge and exactly on it, and random writes cover every other phase. An independent cycle model in the bench decides, from the position of each write, which period the new code governs. It then compares every output sample against the model. Mode and select writes that fall inside a pulse are judged the same way, with a two-edge latency.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
  typedef enum logic [1:0] {
    ADDR_MODE = 2'd0,
    ADDR_SEL  = 2'd1,
    ADDR_DUTY = 2'd2
  } cfg_addr_e;

  localparam int MODE_EN_BIT = 4;
  localparam int FAST_SEL_LO = 4;
  localparam int SYS_SEL_LO  = 6;
  localparam logic [1:0] SEL_ON = 2'b01;
endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_i,
  output logic rise_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], ref_i};
  end

  assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int TICKS = 32,
  localparam int PW = $clog2(TICKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_i,
  output logic [PW-1:0] phase_o,
  output logic          run_o
);
  localparam logic [PW-1:0] LAST = PW'(TICKS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o <= LAST;
      run_o   <= 1'b0;
    end else if (rise_i) begin
      phase_o <= '0;
      run_o   <= 1'b1;
    end else if (phase_o != LAST) begin
      phase_o <= phase_o + 1'b1;
    end else begin
      run_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import dbl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  output logic              mode_en_o,
  output logic              fast_sel_o,
  output logic              sys_sel_o,
  output logic [DUTY_W-1:0] duty_act_o
);
  logic [DATA_W-1:0] mode_q;
  logic [DATA_W-1:0] sel_q;
  logic [DUTY_W-1:0] duty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      sel_q  <= '0;
      duty_q <= '0;
    end else if (we_i) begin
      case (cfg_addr_e'(addr_i))
        ADDR_MODE: mode_q <= wdata_i;
        ADDR_SEL:  sel_q  <= wdata_i;
        ADDR_DUTY: duty_q <= wdata_i[DUTY_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         duty_act_o <= '0;
    else if (rise_i) duty_act_o <= duty_q;
  end

  assign mode_en_o  = mode_q[MODE_EN_BIT];
  assign fast_sel_o = (sel_q[FAST_SEL_LO +: 2] == SEL_ON);
  assign sys_sel_o  = (sel_q[SYS_SEL_LO +: 2] == SEL_ON);
endmodule

// File: rtl/duty_gate.sv
module duty_gate #(
  parameter int TICKS = 32,
  localparam int PW = $clog2(TICKS),
  localparam int CW = PW - 1,
  localparam int DW = 2 * CW
) (
  input  logic [PW-1:0] phase_i,
  input  logic [DW-1:0] duty_i,
  output logic          high_o
);
  logic [CW-1:0] code_a;
  logic [CW-1:0] code_b;
  logic [CW-1:0] offs;

  assign code_a = {duty_i[DW-1], duty_i[DW-3:CW-1]};
  assign code_b = {duty_i[DW-2], duty_i[CW-2:0]};
  assign offs   = phase_i[CW-1:0];
  assign high_o = phase_i[PW-1] ? (offs <= code_b) : (offs <= code_a);
endmodule

// File: rtl/duty_doubler.sv
module duty_doubler #(
  parameter int TICKS     = 32,
  parameter int SYNC_STGS = 2,
  parameter int DATA_W    = 8,
  localparam int PW = $clog2(TICKS),
  localparam int DW = 2 * (PW - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic              fast_clk_o,
  output logic              sys_clk_o
);
  logic          rise;
  logic [PW-1:0] phase;
  logic          run;
  logic          mode_en;
  logic          fast_sel;
  logic          sys_sel;
  logic [DW-1:0] duty_act;
  logic          high;

  ref_edge_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst(rst), .ref_i(ref_i), .rise_o(rise)
  );

  phase_counter #(.TICKS(TICKS)) u_phase (
    .clk(clk), .rst(rst), .rise_i(rise), .phase_o(phase), .run_o(run)
  );

  cfg_bank #(.DATA_W(DATA_W), .DUTY_W(DW)) u_cfg (
    .clk(clk), .rst(rst), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .rise_i(rise), .mode_en_o(mode_en),
    .fast_sel_o(fast_sel), .sys_sel_o(sys_sel), .duty_act_o(duty_act)
  );

  duty_gate #(.TICKS(TICKS)) u_gate (
    .phase_i(phase), .duty_i(duty_act), .high_o(high)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_clk_o <= 1'b0;
      sys_clk_o  <= 1'b0;
    end else begin
      fast_clk_o <= run & mode_en & fast_sel & high;
      sys_clk_o  <= run & mode_en & sys_sel & high;
    end
  end
endmodule

// File: rtl/doubler_chk.sv
module doubler_chk #(
  parameter int PW = 5,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rise,
  input logic [PW-1:0] phase,
  input logic          run,
  input logic          mode_en,
  input logic          fast_sel,
  input logic          sys_sel,
  input logic [DW-1:0] duty_act,
  input logic          fast_o,
  input logic          sys_o
);
  localparam logic [PW-1:0] LAST = '1;

  a_r2_restart: assert property (@(posedge clk) disable iff (rst)
    rise |=> (phase == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (phase == LAST && !rise) |=> (phase == LAST && !run));

  a_r5_reload_only_on_edge: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(duty_act));

  a_r6_mode_off: assert property (@(posedge clk) disable iff (rst)
    !mode_en |=> (!fast_o && !sys_o));

  a_r7_fast_unselected: assert property (@(posedge clk) disable iff (rst)
    !fast_sel |=> !fast_o);

  a_r7_sys_unselected: assert property (@(posedge clk) disable iff (rst)
    !sys_sel |=> !sys_o);

  a_r8_idle_low: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!fast_o && !sys_o));
endmodule

bind duty_doubler doubler_chk #(.PW(PW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .rise(rise), .phase(phase), .run(run),
  .mode_en(mode_en), .fast_sel(fast_sel), .sys_sel(sys_sel),
  .duty_act(duty_act), .fast_o(fast_clk_o), .sys_o(sys_clk_o)
);

// File: tb/tb_duty_doubler.sv
module tb_duty_doubler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [1:0] cfg_addr_i = '0;
  logic [7:0] cfg_wdata_i = '0;
  logic       fast_clk_o, sys_clk_o;

  always #2 clk = ~clk;

  duty_doubler dut (
    .clk(clk), .rst(rst), .ref_i(ref_i), .cfg_we_i(cfg_we_i),
    .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .fast_clk_o(fast_clk_o), .sys_clk_o(sys_clk_o)
  );

  int   errs = 0, checks = 0, cyc = 0;
  bit   running = 1'b0;
  logic [7:0] mode_m = '0, sel_m = '0, pend = '0, cur = '0, prev = '0;
  logic [7:0] mode_q1 = '0, mode_q2 = '0, sel_q1 = '0, sel_q2 = '0;
  bit   cur_v = 1'b0, prev_v = 1'b0, cur_new = 1'b0, prev_new = 1'b0;

  function automatic bit hi(int k, logic [7:0] d);
    if (k < 16) return k <= int'({d[7], d[5:3]});
    return (k - 16) <= int'({d[6], d[2:0]});
  endfunction

  task automatic chk(logic act, logic exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s cyc=%0d actual=%b expected=%b", tag, what, cyc, act, exp);
    end
  endtask

  task automatic step(bit we, logic [1:0] a, logic [7:0] d);
    int k;
    bit v, nw, base;
    logic [7:0] ds;
    string tag;
    @(negedge clk);
    if (cyc % 32 == 0) begin
      prev = cur; prev_v = cur_v; prev_new = cur_new;
      cur_new = (pend != cur); cur = pend; cur_v = running;
    end
    k  = (cyc + 28) % 32;
    v  = (cyc % 32 < 4) ? prev_v : cur_v;
    ds = (cyc % 32 < 4) ? prev : cur;
    nw = (cyc % 32 < 4) ? prev_new : cur_new;
    base = v && mode_q2[4] && hi(k, ds);
    if (!v) tag = "R8";
    else if (!mode_q2[4]) tag = "R6";
    else if (k == 0 || k == 16) tag = "R2";
    else if (nw) tag = "R5";
    else if (k < 16) tag = "R3";
    else tag = "R4";
    chk(fast_clk_o, base && sel_q2[5:4] == 2'b01,
        (v && mode_q2[4] && sel_q2[5:4] != 2'b01) ? "R7" : tag, "fast");
    chk(sys_clk_o, base && sel_q2[7:6] == 2'b01,
        (v && mode_q2[4] && sel_q2[7:6] != 2'b01) ? "R7" : tag, "sys");
    ref_i = running && (cyc % 32 < 16);
    cfg_we_i = we; cfg_addr_i = a; cfg_wdata_i = d;
    if (we) begin
      case (a)
        2'd0: mode_m = d;
        2'd1: sel_m = d;
        2'd2: begin
          pend = d;
          if (cyc % 32 <= 1) begin cur_new = cur_new || (cur != d); cur = d; end
        end
        default: ;  // R9: unmapped address, no model change
      endcase
    end
    mode_q2 = mode_q1; mode_q1 = mode_m;
    sel_q2 = sel_q1; sel_q1 = sel_m;
    cyc++;
  endtask

  task automatic idle_to(int p);
    do step(1'b0, 2'd0, 8'h00); while (cyc % 32 != p);
  endtask

  task automatic wr_at(int p, logic [1:0] a, logic [7:0] d);
    while (cyc % 32 != p) step(1'b0, 2'd0, 8'h00);
    step(1'b1, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] directed [6] = '{8'h00, 8'h3F, 8'hC0, 8'hF6, 8'hFF, 8'h8A};
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(fast_clk_o, 1'b0, "R1", "fast in reset");
    chk(sys_clk_o, 1'b0, "R1", "sys in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(fast_clk_o, 1'b0, "R1", "fast after reset");
    chk(sys_clk_o, 1'b0, "R1", "sys after reset");
    running = 1'b1;
    step(1'b1, 2'd0, 8'h10);
    step(1'b1, 2'd1, 8'h50);
    step(1'b1, 2'd2, 8'h00);
    // R3/R4: directed duty codes, written mid-period
    foreach (directed[i]) begin
      wr_at(10, 2'd2, directed[i]);
      idle_to(0); idle_to(0);
    end
    // R5: write one tick before the reload edge, then on the reload edge
    wr_at(1, 2'd2, 8'h5B);
    idle_to(0);
    wr_at(2, 2'd2, 8'hA4);
    idle_to(0); idle_to(0);
    // R7: select variants
    wr_at(20, 2'd1, 8'h10); idle_to(0); idle_to(0);
    wr_at(20, 2'd1, 8'h40); idle_to(0); idle_to(0);
    wr_at(20, 2'd1, 8'h70); idle_to(0); idle_to(0);
    wr_at(20, 2'd1, 8'h50);
    // R9: unmapped write
    wr_at(12, 2'd3, 8'hFF); idle_to(0); idle_to(0);
    // R6: mode off then back on
    wr_at(6, 2'd0, 8'hEF); idle_to(0); idle_to(0);
    wr_at(6, 2'd0, 8'h10); idle_to(0);
    // R8: reference stops, with code 15 in the second half
    wr_at(8, 2'd2, 8'h7F); idle_to(0);
    running = 1'b0;
    repeat (3) idle_to(0);
    running = 1'b1;
    idle_to(0); idle_to(0);
    // constrained random
    for (int p = 0; p < 160; p++) begin
      if (p % 40 == 39) running = 1'b0;
      else running = 1'b1;
      for (int t = 0; t < 32; t++) begin
        if ($urandom % 12 == 0) begin
          int unsigned r = $urandom % 10;
          logic [7:0] d = 8'($urandom);
          if (r < 5) step(1'b1, 2'd2, d);
          else if (r < 7) step(1'b1, 2'd0, ($urandom % 4 != 0) ? (d | 8'h10) : d);
          else if (r < 9) begin
            int unsigned s = $urandom % 4;
            step(1'b1, 2'd1, s == 0 ? 8'h50 : s == 1 ? 8'h10 : s == 2 ? 8'h40 : d);
          end else step(1'b1, 2'd3, d);
        end else step(1'b0, 2'd0, 8'h00);
      end
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule